// File: doc/BRIEF.md
# Triggered DMA Channel Controller

This block is one DMA channel. It copies a run of 16-bit or 32-bit units from a source address to a destination address over a simple request/ready memory bus. Each unit takes one read and then one write. Software programs four registers: source, destination, unit count and control. The control register chooses the event that starts a run: the enable bit being set, a vertical blank pulse, a horizontal blank pulse, or a sound FIFO request.

The channel keeps its own working copies of the source, the destination and the remaining count. Blank events re-arm a repeating channel by reloading the working count and, if the destination mode asks for it, the working destination. A sound request replaces the programmed settings with a fixed burst of four units to one of two FIFO addresses. When a run ends, the channel pulses its own interrupt line if interrupts are enabled. It then either stays armed (repeat) or clears its own enable bit.

A parameter gives the channel's index. Only channels 1 and 2 react to sound requests. Arbitration between channels and interrupt collection are handled elsewhere.

Top module: `dma_chan_ctrl`

## Requirements
- R1: While reset is held and straight after it, no bus read or write is requested and the interrupt output is low.
- R2: Each unit is one read at the working source followed by one write of the read data at the working destination. Each request is held until `bus_ready` is high. Control bit 5 selects 32-bit units (1) or 16-bit units (0), and the address step is 4 or 2 bytes to match.
- R3: The address modes are in control bits 1:0 (destination) and 3:2 (source): 00 steps up, 01 steps down, 10 holds the address, 11 steps up with reload.
- R4: The start mode is in control bits 7:6: 00 immediate, 01 vertical blank, 10 horizontal blank, 11 sound FIFO. When software sets enable (control bit 9) from 0 to 1, the working source, destination and count load from the programmed registers. If the start mode is 00, a run starts. Register select values are 0 source, 1 destination, 2 count, 3 control.
- R5: A programmed count of zero means the largest count, 2^CNT_W-1 units.
- R6: A vertical blank pulse starts a run only on an enabled channel in mode 01. A horizontal blank pulse starts a run only on an enabled channel in mode 10.
- R7: A blank pulse has no effect while a run is in progress.
- R8: On a blank-started run, the working count reloads from the programmed count. The working destination reloads from the programmed destination only in destination mode 11. In every other mode it continues from where the last run left it, and so does the working source.
- R9: When the last unit's write is accepted, the interrupt output pulses high for exactly one cycle, on the next cycle, if control bit 8 is set. Otherwise it stays low.
- R10: At the end of a run with repeat (control bit 4) clear, the channel clears its enable bit, so later triggers are ignored. With repeat set, it stays enabled.
- R11: On a sound-capable channel in mode 11 that is not busy, a sound request starts a burst of 4 units. The destination is 0x040000A0 when `snd_fifo_sel` is 0 and 0x040000A4 when it is 1, and it stays fixed for all 4 units. The request also forces the repeat bit on.
- R12: A sound request is dropped while a run is in progress, and also when the start mode is not 11.
- R13: A channel whose index is not 1 or 2 ignores sound requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| vblank_pulse | input | 1 | Vertical blank event, one cycle |
| hblank_pulse | input | 1 | Horizontal blank event, one cycle |
| snd_req | input | 1 | Sound FIFO refill request, one cycle |
| snd_fifo_sel | input | 1 | Chooses which FIFO address the sound burst targets |
| bus_rd_req | output | 1 | Read request |
| bus_wr_req | output | 1 | Write request |
| bus_addr | output | ADDR_W | Address of the current request |
| bus_wide | output | 1 | Unit is 32-bit when high, 16-bit when low |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Memory accepts the current request |
| irq_pulse | output | 1 | Single-cycle end-of-run interrupt |

## Verification
The main copy path is exercised with four address patterns: rising 16-bit steps, falling 32-bit source steps into a held destination under a stalling bus, a held source and destination with the maximum count, and sound bursts into the two FIFO addresses. The read data encodes the address it came from, so each logged write shows whether the source stepped the right way and the destination landed in the right place. The trigger patterns are a wrong-type blank, a blank during a run, two runs back to back in reload and non-reload destination modes, a trigger after a non-repeating run, and sound requests that arrive while busy, in the wrong mode, or on a channel that cannot take them. Together these separate a reload from a continuation, an ignored trigger from a late one, and this channel's interrupt from a missing one.

// File: rtl/dma_chan_pkg.sv
// Shared encodings for the DMA channel: control word layout, start and
// address-step modes, register selects and the sound FIFO addresses.
// Assumes a bus data path of 32 bits.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        TM_NOW = 2'b00,
        TM_VBL = 2'b01,
        TM_HBL = 2'b10,
        TM_SND = 2'b11
    } start_mode_e;

    typedef enum logic [1:0] {
        STEP_UP     = 2'b00,
        STEP_DOWN   = 2'b01,
        STEP_HOLD   = 2'b10,
        STEP_UP_RLD = 2'b11
    } step_mode_e;

    // Packed MSB first: enable is bit 9, dst_step is bits 1:0.
    typedef struct packed {
        logic        enable;
        logic        irq_en;
        start_mode_e start;
        logic        wide;
        logic        rpt;
        step_mode_e  src_step;
        step_mode_e  dst_step;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);
    localparam int DATA_W = 32;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam logic [31:0] FIFO_ADDR_A = 32'h0400_00A0;
    localparam logic [31:0] FIFO_ADDR_B = 32'h0400_00A4;
    localparam int          SND_UNITS   = 4;

endpackage

// File: rtl/dma_chan_regs.sv
// Programmed register file of one channel: source, destination, count and
// control. The hardware can clear the enable bit and force the repeat bit;
// both of these take precedence over a software write in the same cycle.
// Assumes ADDR_W <= 32.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              clr_enable,
    input  logic              set_repeat,
    output logic [ADDR_W-1:0] prog_src,
    output logic [ADDR_W-1:0] prog_dst,
    output logic [CNT_W-1:0]  prog_cnt,
    output chan_ctrl_t        ctrl
);

    // Register writes, then hardware overrides on the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_src <= '0;
            prog_dst <= '0;
            prog_cnt <= '0;
            ctrl     <= '0;
        end else begin
            if (reg_we) begin
                case (reg_sel)
                    SEL_SRC:  prog_src <= reg_wdata[ADDR_W-1:0];
                    SEL_DST:  prog_dst <= reg_wdata[ADDR_W-1:0];
                    SEL_CNT:  prog_cnt <= reg_wdata[CNT_W-1:0];
                    default:  ctrl     <= chan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
                endcase
            end
            if (set_repeat) ctrl.rpt    <= 1'b1;
            if (clr_enable) ctrl.enable <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_chan_trigger.sv
// Start logic: turns the enable edge, the blank pulses and sound requests
// into one start strobe plus load strobes for the working copies.
// Priority: sound request, then enable edge, then blank. Every trigger is
// ignored while the engine is busy.
module dma_chan_trigger
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14,
    parameter bit SND_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  start_mode_e       start_mode,
    input  step_mode_e        dst_step,
    input  logic [ADDR_W-1:0] prog_src,
    input  logic [ADDR_W-1:0] prog_dst,
    input  logic [CNT_W-1:0]  prog_cnt,
    input  logic              busy,
    input  logic              vblank,
    input  logic              hblank,
    input  logic              snd_req,
    input  logic              snd_fifo_sel,
    output logic              start,
    output logic              snd_mode,
    output logic              set_repeat,
    output logic              ld_src,
    output logic              ld_dst,
    output logic              ld_cnt,
    output logic [ADDR_W-1:0] new_src,
    output logic [ADDR_W-1:0] new_dst,
    output logic [CNT_W-1:0]  new_cnt
);

    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
    localparam logic [CNT_W-1:0]  CNT_SND   = CNT_W'(SND_UNITS);
    localparam logic [ADDR_W-1:0] FIFO_A_AW = FIFO_ADDR_A[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] FIFO_B_AW = FIFO_ADDR_B[ADDR_W-1:0];

    logic              en_d;
    logic              en_rise;
    logic              blank_hit;
    logic              snd_hit;
    logic [CNT_W-1:0]  full_cnt;
    logic [ADDR_W-1:0] fifo_addr;

    // Previous enable value, used to find the 0-to-1 edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= enable;
    end

    assign en_rise   = enable && !en_d && !busy;
    assign blank_hit = !busy && enable &&
                       ((vblank && start_mode == TM_VBL) ||
                        (hblank && start_mode == TM_HBL));
    assign snd_hit   = SND_OK && !busy && snd_req && start_mode == TM_SND;
    assign full_cnt  = (prog_cnt == '0) ? CNT_MAX : prog_cnt;
    assign fifo_addr = snd_fifo_sel ? FIFO_B_AW : FIFO_A_AW;
    assign new_src   = prog_src;

    // Pick the start source and what the working copies load from.
    always_comb begin
        start      = 1'b0;
        snd_mode   = 1'b0;
        set_repeat = 1'b0;
        ld_src     = 1'b0;
        ld_dst     = 1'b0;
        ld_cnt     = 1'b0;
        new_dst    = prog_dst;
        new_cnt    = full_cnt;
        if (snd_hit) begin
            start      = 1'b1;
            snd_mode   = 1'b1;
            set_repeat = 1'b1;
            ld_dst     = 1'b1;
            ld_cnt     = 1'b1;
            new_dst    = fifo_addr;
            new_cnt    = CNT_SND;
        end else begin
            if (en_rise) begin
                ld_src = 1'b1;
                ld_dst = 1'b1;
                ld_cnt = 1'b1;
                start  = (start_mode == TM_NOW);
            end
            if (blank_hit) begin
                start  = 1'b1;
                ld_cnt = 1'b1;
                if (dst_step == STEP_UP_RLD) ld_dst = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_chan_engine.sv
// Transfer engine: holds the working source, destination and count, and
// moves one unit per read/write pair on a request/ready bus. Loads are
// accepted only while idle. In sound mode the destination is held.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              snd_mode,
    input  logic              ld_src,
    input  logic              ld_dst,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] new_src,
    input  logic [ADDR_W-1:0] new_dst,
    input  logic [CNT_W-1:0]  new_cnt,
    input  logic              wide,
    input  step_mode_e        src_step,
    input  step_mode_e        dst_step,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              finish,
    output logic              bus_rd_req,
    output logic              bus_wr_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_e;

    eng_state_e        state;
    logic [ADDR_W-1:0] wk_src;
    logic [ADDR_W-1:0] wk_dst;
    logic [CNT_W-1:0]  wk_cnt;
    logic [DATA_W-1:0] data_q;
    logic              snd_q;

    function automatic logic [ADDR_W-1:0] next_addr(
        input logic [ADDR_W-1:0] a, input step_mode_e m, input logic w);
        logic [ADDR_W-1:0] delta;
        delta = w ? ADDR_W'(4) : ADDR_W'(2);
        case (m)
            STEP_DOWN: next_addr = a - delta;
            STEP_HOLD: next_addr = a;
            default:   next_addr = a + delta;
        endcase
    endfunction

    assign busy       = (state != ST_IDLE);
    assign bus_rd_req = (state == ST_RD);
    assign bus_wr_req = (state == ST_WR);
    assign bus_addr   = (state == ST_WR) ? wk_dst : wk_src;
    assign bus_wdata  = data_q;
    assign finish     = (state == ST_WR) && bus_ready && (wk_cnt == CNT_W'(1));

    // Sequencer and working copies: load, read, write, step, count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wk_src <= '0;
            wk_dst <= '0;
            wk_cnt <= '0;
            data_q <= '0;
            snd_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ld_src) wk_src <= new_src;
                    if (ld_dst) wk_dst <= new_dst;
                    if (ld_cnt) wk_cnt <= new_cnt;
                    if (start) begin
                        state <= ST_RD;
                        snd_q <= snd_mode;
                    end
                end
                ST_RD: begin
                    if (bus_ready) begin
                        data_q <= bus_rdata;
                        state  <= ST_WR;
                    end
                end
                default: begin
                    if (bus_ready) begin
                        wk_src <= next_addr(wk_src, src_step, wide);
                        wk_dst <= snd_q ? wk_dst : next_addr(wk_dst, dst_step, wide);
                        wk_cnt <= wk_cnt - CNT_W'(1);
                        state  <= (wk_cnt == CNT_W'(1)) ? ST_IDLE : ST_RD;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
// Top of one DMA channel: register file, trigger logic and transfer engine.
// Drives its own single-cycle interrupt at the end of each run and clears
// its enable bit when the run was not repeating.
// Assumes ADDR_W <= 32 and CNT_W >= 3.
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int CH_ID  = 1,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              vblank_pulse,
    input  logic              hblank_pulse,
    input  logic              snd_req,
    input  logic              snd_fifo_sel,
    output logic              bus_rd_req,
    output logic              bus_wr_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wide,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready,
    output logic              irq_pulse
);

    localparam bit SND_OK = (CH_ID == 1) || (CH_ID == 2);

    chan_ctrl_t        ctrl;
    logic [ADDR_W-1:0] prog_src;
    logic [ADDR_W-1:0] prog_dst;
    logic [CNT_W-1:0]  prog_cnt;
    logic              clr_enable;
    logic              set_repeat;
    logic              trig_start;
    logic              trig_snd;
    logic              snd_start;
    logic              ld_src;
    logic              ld_dst;
    logic              ld_cnt;
    logic [ADDR_W-1:0] new_src;
    logic [ADDR_W-1:0] new_dst;
    logic [CNT_W-1:0]  new_cnt;
    logic              busy;
    logic              finish;
    logic              irq_q;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .clr_enable (clr_enable),
        .set_repeat (set_repeat),
        .prog_src   (prog_src),
        .prog_dst   (prog_dst),
        .prog_cnt   (prog_cnt),
        .ctrl       (ctrl)
    );

    dma_chan_trigger #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SND_OK(SND_OK)) u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ctrl.enable),
        .start_mode   (ctrl.start),
        .dst_step     (ctrl.dst_step),
        .prog_src     (prog_src),
        .prog_dst     (prog_dst),
        .prog_cnt     (prog_cnt),
        .busy         (busy),
        .vblank       (vblank_pulse),
        .hblank       (hblank_pulse),
        .snd_req      (snd_req),
        .snd_fifo_sel (snd_fifo_sel),
        .start        (trig_start),
        .snd_mode     (trig_snd),
        .set_repeat   (set_repeat),
        .ld_src       (ld_src),
        .ld_dst       (ld_dst),
        .ld_cnt       (ld_cnt),
        .new_src      (new_src),
        .new_dst      (new_dst),
        .new_cnt      (new_cnt)
    );

    dma_chan_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (trig_start),
        .snd_mode   (trig_snd),
        .ld_src     (ld_src),
        .ld_dst     (ld_dst),
        .ld_cnt     (ld_cnt),
        .new_src    (new_src),
        .new_dst    (new_dst),
        .new_cnt    (new_cnt),
        .wide       (ctrl.wide),
        .src_step   (ctrl.src_step),
        .dst_step   (ctrl.dst_step),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .finish     (finish),
        .bus_rd_req (bus_rd_req),
        .bus_wr_req (bus_wr_req),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata)
    );

    assign snd_start  = trig_start && trig_snd;
    assign clr_enable = finish && !ctrl.rpt;
    assign bus_wide   = ctrl.wide;
    assign irq_pulse  = irq_q;

    // End-of-run interrupt, one cycle after the last write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= finish && ctrl.irq_en;
    end

endmodule

// File: rtl/dma_chan_checker.sv
// Protocol and end-of-run properties for dma_chan_ctrl, attached by bind.
// Looks at the bus ports and at the top's finish, enable and repeat state.
module dma_chan_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd_req,
    input logic              bus_wr_req,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq,
    input logic              finish,
    input logic              enable,
    input logic              rpt,
    input logic              reg_we,
    input logic              snd_start
);

    assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_req && bus_wr_req));

    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_req && bus_ready) |=> bus_wr_req);

    assert_write_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_req && !bus_ready) |=> (bus_wr_req && $stable(bus_addr)));

    assert_irq_follows_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(finish));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_enable_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !rpt) |=> !enable);

    assert_enable_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && rpt && enable && !reg_we) |=> enable);

    assert_sound_forces_repeat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snd_start |=> rpt);

endmodule

bind dma_chan_ctrl dma_chan_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd_req (bus_rd_req),
    .bus_wr_req (bus_wr_req),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .irq        (irq_pulse),
    .finish     (finish),
    .enable     (ctrl.enable),
    .rpt        (ctrl.rpt),
    .reg_we     (reg_we),
    .snd_start  (snd_start)
);

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 8;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        vblank_pulse = 1'b0;
    logic        hblank_pulse = 1'b0;
    logic        snd_req = 1'b0;
    logic        snd_fifo_sel = 1'b0;
    logic        bus_rd_req, bus_wr_req, bus_wide, irq_pulse;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = 32'd0;
    logic        bus_ready = 1'b0;
    // second channel, index 0, cannot take sound requests
    logic        b_rd, b_wr, b_wide, b_irq;
    logic [31:0] b_addr, b_wdata;
    logic        b_ready = 1'b1;
    logic [31:0] b_rdata = 32'd0;

    int total = 0;
    int bad = 0;
    int wr_n = 0;
    int rd_n = 0;
    int irq_n = 0;
    int rd2_n = 0;
    int cycles = 0;
    logic stall_en = 1'b0;
    logic stall_tog = 1'b0;
    logic [31:0] wa [0:511];
    logic [31:0] wd [0:511];

    always #10 clk = ~clk;

    dma_chan_ctrl #(.CH_ID(1), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .vblank_pulse(vblank_pulse),
        .hblank_pulse(hblank_pulse), .snd_req(snd_req),
        .snd_fifo_sel(snd_fifo_sel), .bus_rd_req(bus_rd_req),
        .bus_wr_req(bus_wr_req), .bus_addr(bus_addr), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .irq_pulse(irq_pulse));

    dma_chan_ctrl #(.CH_ID(0), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_ch0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .vblank_pulse(vblank_pulse),
        .hblank_pulse(hblank_pulse), .snd_req(snd_req),
        .snd_fifo_sel(snd_fifo_sel), .bus_rd_req(b_rd),
        .bus_wr_req(b_wr), .bus_addr(b_addr), .bus_wide(b_wide),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .bus_ready(b_ready),
        .irq_pulse(b_irq));

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    function automatic logic [31:0] cw(input logic en, input logic irq,
        input logic [1:0] tm, input logic wide, input logic rpt,
        input logic [1:0] sadj, input logic [1:0] dadj);
        return {22'd0, en, irq, tm, wide, rpt, sadj, dadj};
    endfunction

    // Memory model: ready, read data and the write log, all at the negedge.
    initial begin
        forever begin
            @(negedge clk);
            stall_tog = ~stall_tog;
            bus_ready = stall_en ? stall_tog : 1'b1;
            bus_rdata = pat(bus_addr);
            if (bus_wr_req && bus_ready && wr_n < 512) begin
                wa[wr_n] = bus_addr;
                wd[wr_n] = bus_wdata;
                wr_n++;
            end
            if (bus_rd_req && bus_ready) rd_n++;
            if (irq_pulse) irq_n++;
            if (b_rd) rd2_n++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_v();
        @(negedge clk); vblank_pulse = 1'b1;
        @(negedge clk); vblank_pulse = 1'b0;
    endtask

    task automatic pulse_h();
        @(negedge clk); hblank_pulse = 1'b1;
        @(negedge clk); hblank_pulse = 1'b0;
    endtask

    task automatic pulse_s(input logic sel);
        @(negedge clk); snd_req = 1'b1; snd_fifo_sel = sel;
        @(negedge clk); snd_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] c, input logic [31:0] ctl);
        wr_reg(2'd3, 32'd0);
        wr_reg(2'd0, s);
        wr_reg(2'd1, d);
        wr_reg(2'd2, c);
        wr_reg(2'd3, ctl);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rd during reset", {31'd0, bus_rd_req}, 32'd0);
        check("R1 irq during reset", {31'd0, irq_pulse}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        check("R1 no request after reset", {30'd0, bus_rd_req, bus_wr_req}, 32'd0);
        check("R1 irq low after reset", {31'd0, irq_pulse}, 32'd0);
    endtask

    task automatic t_immediate();
        int b = wr_n;
        int bi = irq_n;
        setup(32'h1000, 32'h2000, 32'd3, cw(1, 1, 2'b00, 0, 0, 2'b00, 2'b00));
        idle(20);
        check("R4 immediate unit count", wr_n - b, 3);
        for (int i = 0; i < 3; i++) begin
            check("R3 up-step destination", wa[b+i], 32'h2000 + 2*i);
            check("R2 16-bit data from stepped source", {16'd0, wd[b+i][15:0]}, 32'h1000 + 2*i);
        end
        check("R9 one interrupt", irq_n - bi, 1);
    endtask

    task automatic t_wide_stall();
        int b = wr_n;
        int bi = irq_n;
        stall_en = 1'b1;
        setup(32'h3000, 32'h4000, 32'd2, cw(1, 0, 2'b00, 1, 0, 2'b01, 2'b10));
        idle(40);
        stall_en = 1'b0;
        check("R2 wide unit count", wr_n - b, 2);
        check("R3 held destination 0", wa[b], 32'h4000);
        check("R3 held destination 1", wa[b+1], 32'h4000);
        check("R2 32-bit data 0", wd[b], pat(32'h3000));
        check("R3 down-step source by 4", wd[b+1], pat(32'h2FFC));
        check("R9 no interrupt when disabled", irq_n - bi, 0);
    endtask

    task automatic t_vblank();
        int b = wr_n;
        int bi = irq_n;
        setup(32'h1100, 32'h2200, 32'd2, cw(1, 1, 2'b01, 0, 0, 2'b00, 2'b00));
        idle(10);
        check("R6 no start on enable in blank mode", wr_n - b, 0);
        pulse_h();
        idle(10);
        check("R6 wrong blank type ignored", wr_n - b, 0);
        pulse_v();
        idle(20);
        check("R6 vblank starts run", wr_n - b, 2);
        check("R6 vblank destination", wa[b+1], 32'h2202);
        check("R9 vblank interrupt", irq_n - bi, 1);
        pulse_v();
        idle(20);
        check("R10 non-repeat run disables channel", wr_n - b, 2);
    endtask

    task automatic t_hblank_reload();
        int b = wr_n;
        int bi = irq_n;
        setup(32'h5000, 32'h6000, 32'd2, cw(1, 1, 2'b10, 0, 1, 2'b00, 2'b11));
        pulse_h();
        pulse_h();
        idle(20);
        check("R7 blank during run ignored", wr_n - b, 2);
        pulse_h();
        idle(20);
        check("R10 repeat keeps channel armed", wr_n - b, 4);
        check("R8 destination reloaded", wa[b+2], 32'h6000);
        check("R8 reloaded destination steps", wa[b+3], 32'h6002);
        check("R8 source continues", {16'd0, wd[b+2][15:0]}, 32'h5004);
        check("R9 interrupt per run", irq_n - bi, 2);
    endtask

    task automatic t_hblank_continue();
        int b = wr_n;
        setup(32'h7100, 32'h7000, 32'd2, cw(1, 0, 2'b10, 0, 1, 2'b00, 2'b00));
        pulse_h();
        idle(20);
        pulse_h();
        idle(20);
        check("R8 count reloaded for second run", wr_n - b, 4);
        check("R8 destination continues", wa[b+2], 32'h7004);
        check("R8 destination continues last", wa[b+3], 32'h7006);
    endtask

    task automatic t_zero_max();
        int b = wr_n;
        setup(32'h0100, 32'h0200, 32'd0, cw(1, 0, 2'b00, 0, 0, 2'b10, 2'b10));
        idle(2 * 255 + 30);
        check("R5 zero count runs maximum", wr_n - b, 255);
        check("R5 held address", wa[b+254], 32'h0200);
    endtask

    task automatic t_sound();
        int b = wr_n;
        int bi = irq_n;
        setup(32'h9000, 32'h8000, 32'd9, cw(1, 1, 2'b11, 1, 0, 2'b00, 2'b00));
        idle(5);
        check("R11 no start before request", wr_n - b, 0);
        pulse_s(1'b1);
        pulse_s(1'b0);
        idle(30);
        check("R12 busy request dropped", wr_n - b, 4);
        for (int i = 0; i < 4; i++) begin
            check("R11 FIFO B fixed destination", wa[b+i], 32'h0400_00A4);
            check("R11 sound source data", wd[b+i], pat(32'h9000 + 4*i));
        end
        check("R11 sound interrupt", irq_n - bi, 1);
        pulse_s(1'b0);
        idle(30);
        check("R11 second burst count", wr_n - b, 8);
        check("R11 FIFO A destination", wa[b+7], 32'h0400_00A0);
        wr_reg(2'd3, cw(1, 1, 2'b01, 1, 1, 2'b00, 2'b00));
        pulse_s(1'b0);
        idle(30);
        check("R12 wrong mode request dropped", wr_n - b, 8);
    endtask

    task automatic t_no_sound_ch0();
        int b = wr_n;
        int b2;
        setup(32'hA000, 32'hB000, 32'd2, cw(1, 0, 2'b11, 0, 0, 2'b00, 2'b00));
        idle(5);
        b2 = rd2_n;
        pulse_s(1'b0);
        idle(30);
        check("R13 channel 0 ignores sound", rd2_n - b2, 0);
        check("R11 channel 1 takes same request", wr_n - b, 4);
    endtask

    initial begin
        idle(3);
        t_reset();
        t_immediate();
        t_wide_stall();
        t_vblank();
        t_hblank_reload();
        t_hblank_continue();
        t_zero_max();
        t_sound();
        t_no_sound_ch0();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule